// File: doc/BRIEF.md
# FP32 Operand and Result Modifier Stage

This block wraps a single-precision vector operation with the cheap modifiers that a long instruction encoding carries for free. Before the operation, each of three source operands can be negated, given its absolute value, or turned into the negative of its absolute value. After the operation, the result can be scaled by 0.5, 1, 2 or 4 and can then be clamped to the closed unit interval. The operation itself is not part of the block. Its inputs leave through the pre-stage outputs, and its result comes back through the post-stage inputs.

Every lane is handled independently. The lane count is a parameter, and lane `i` occupies bits `[32*i+31:32*i]` of each packed bus. The modifier controls come from the instruction, so all lanes share them. Each stage registers its outputs once. The two stages have separate valid strobes so that a pipeline of any length can sit between them.

Scaling works by adjusting the exponent field, so the block contains no multiplier. Values that overflow become a signed infinity. Values that would land in the subnormal range become a signed zero.

Top module: `fp32_modifier_stage`

## Requirements
- R1: With only the negate control of an input set, the output keeps bits 30:0 and inverts bit 31, including for NaN patterns.
- R2: With only the absolute control of an input set, the output keeps bits 30:0 and has bit 31 cleared.
- R3: With both controls of an input set, the output keeps bits 30:0 and has bit 31 set. With neither set, the input passes through unchanged.
- R4: Each of the three inputs uses its own control bits. Index k of `neg_i`/`abs_i` belongs to source k.
- R5: Scale code 2'b00 selects 1.0 and returns the result bits unchanged, subnormals included.
- R6: Scale codes 2'b01 (2.0) and 2'b10 (4.0) add 1 and 2 to the exponent field. A result exponent of 255 or more gives a signed infinity (exponent all ones, mantissa zero).
- R7: Scale code 2'b11 (0.5) subtracts 1 from the exponent field. Under any scale code other than 2'b00, a result with exponent field 0, or a zero or subnormal input, gives a zero that keeps the sign.
- R8: Infinity and NaN inputs (exponent field all ones) pass through scaling unchanged.
- R9: When clamp is set, the clamp acts on the scaled value. NaN, -0.0 and every negative value become +0.0. Values above 1.0 become 1.0 (0x3F800000). All other values pass through unchanged.
- R10: Each stage registers its outputs one clock after its valid input. The output valid follows the input valid by one cycle. The data outputs hold their value while the valid input is low. Reset clears every output to zero.
- R11: Lanes are independent. Each lane's output depends only on the same lane's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Source operands valid |
| neg_i | input | 3 | Negate control, bit k for source k |
| abs_i | input | 3 | Absolute-value control, bit k for source k |
| src0_i | input | 32*LANES | Source operand 0, packed lanes |
| src1_i | input | 32*LANES | Source operand 1, packed lanes |
| src2_i | input | 32*LANES | Source operand 2, packed lanes |
| op_valid_o | output | 1 | Modified operands valid |
| src0_o | output | 32*LANES | Modified operand 0 |
| src1_o | output | 32*LANES | Modified operand 1 |
| src2_o | output | 32*LANES | Modified operand 2 |
| res_valid_i | input | 1 | Operation result valid |
| omod_i | input | 2 | Scale code: 00 x1, 01 x2, 10 x4, 11 x0.5 |
| clamp_i | input | 1 | Clamp the scaled result to [0,1] |
| res_i | input | 32*LANES | Operation result, packed lanes |
| res_valid_o | output | 1 | Final result valid |
| res_o | output | 32*LANES | Scaled and clamped result |

## Verification
The only state in the block is the output registers and the two valid flags, so a fault shows at the ports exactly one clock after the transaction that exposes it. A wrong sign rule appears on the first operand whose bit 31 disagrees with its control bits. A wrong exponent offset or overflow limit appears on the first result near 1.0, near the top of the exponent range or at the subnormal boundary. A clamp applied before the scale appears on a value just under 1.0 scaled up. A missing hold or a mis-timed valid appears the cycle after a strobe drops.

// File: rtl/fp32_modifier_stage.sv
module fp32_modifier_stage #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid_i,
  input  logic [2:0]            neg_i,
  input  logic [2:0]            abs_i,
  input  logic [32*LANES-1:0]   src0_i,
  input  logic [32*LANES-1:0]   src1_i,
  input  logic [32*LANES-1:0]   src2_i,
  output logic                  op_valid_o,
  output logic [32*LANES-1:0]   src0_o,
  output logic [32*LANES-1:0]   src1_o,
  output logic [32*LANES-1:0]   src2_o,
  input  logic                  res_valid_i,
  input  logic [1:0]            omod_i,
  input  logic                  clamp_i,
  input  logic [32*LANES-1:0]   res_i,
  output logic                  res_valid_o,
  output logic [32*LANES-1:0]   res_o
);
  localparam int W = 32 * LANES;
  localparam logic [31:0] ONE = 32'h3F80_0000;

  function automatic logic [31:0] sign_mod(input logic [31:0] x, input logic n, input logic a);
    logic s;
    s = (a ? 1'b0 : x[31]) ^ n;
    return {s, x[30:0]};
  endfunction

  function automatic logic [31:0] scale(input logic [31:0] x, input logic [1:0] m);
    logic [9:0] e;
    if (m == 2'b00 || x[30:23] == 8'hFF) return x;
    if (x[30:23] == 8'h00) return {x[31], 31'd0};
    case (m)
      2'b01:   e = {2'b00, x[30:23]} + 10'd1;
      2'b10:   e = {2'b00, x[30:23]} + 10'd2;
      default: e = {2'b00, x[30:23]} - 10'd1;
    endcase
    if (e >= 10'd255) return {x[31], 8'hFF, 23'd0};
    if (e == 10'd0) return {x[31], 31'd0};
    return {x[31], e[7:0], x[22:0]};
  endfunction

  function automatic logic [31:0] unit_clamp(input logic [31:0] x);
    if (x[30:23] == 8'hFF && x[22:0] != 23'd0) return 32'd0;
    if (x[31]) return 32'd0;
    if (x[30:0] > ONE[30:0]) return ONE;
    return x;
  endfunction

  logic [W-1:0] s0_n, s1_n, s2_n, r_n;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      s0_n[32*l +: 32] = sign_mod(src0_i[32*l +: 32], neg_i[0], abs_i[0]);
      s1_n[32*l +: 32] = sign_mod(src1_i[32*l +: 32], neg_i[1], abs_i[1]);
      s2_n[32*l +: 32] = sign_mod(src2_i[32*l +: 32], neg_i[2], abs_i[2]);
      r_n[32*l +: 32]  = clamp_i ? unit_clamp(scale(res_i[32*l +: 32], omod_i))
                                 : scale(res_i[32*l +: 32], omod_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid_o  <= 1'b0;
      res_valid_o <= 1'b0;
      src0_o      <= '0;
      src1_o      <= '0;
      src2_o      <= '0;
      res_o       <= '0;
    end else begin
      op_valid_o  <= op_valid_i;
      res_valid_o <= res_valid_i;
      if (op_valid_i) begin
        src0_o <= s0_n;
        src1_o <= s1_n;
        src2_o <= s2_n;
      end
      if (res_valid_i) res_o <= r_n;
    end
  end
endmodule

// File: rtl/fp32_modifier_stage_chk.sv
module fp32_modifier_stage_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid_i,
  input logic [2:0]          neg_i,
  input logic [2:0]          abs_i,
  input logic [32*LANES-1:0] src0_i,
  input logic                op_valid_o,
  input logic [32*LANES-1:0] src0_o,
  input logic                res_valid_i,
  input logic [1:0]          omod_i,
  input logic                clamp_i,
  input logic                res_valid_o,
  input logic [32*LANES-1:0] res_o
);
  assert_op_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o == $past(op_valid_i));
  assert_res_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o == $past(res_valid_i));
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid_i) |-> $stable(src0_o));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assert_neg_flips_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid_i && neg_i[0] && !abs_i[0]) |-> src0_o[32*l+31] == !$past(src0_i[32*l+31]));
    assert_abs_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid_i && abs_i[0] && !neg_i[0]) |-> !src0_o[32*l+31]);
    assert_negabs_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid_i && abs_i[0] && neg_i[0]) |-> src0_o[32*l+31]);
    assert_magnitude_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_valid_i) |-> src0_o[32*l +: 31] == $past(src0_i[32*l +: 31]));
    assert_no_subnormal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(res_valid_i && omod_i != 2'b00) |->
        (res_o[32*l+23 +: 8] != 8'h00 || res_o[32*l +: 23] == 23'd0));
    assert_clamp_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(res_valid_i && clamp_i) |-> res_o[32*l +: 32] <= 32'h3F80_0000);
  end
endmodule

bind fp32_modifier_stage fp32_modifier_stage_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/fp32_modifier_stage_tb.sv
`timescale 1ns/1ps
module fp32_modifier_stage_tb;
  localparam int LANES = 4;
  localparam int W = 32 * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid_i = 1'b0, res_valid_i = 1'b0, clamp_i = 1'b0;
  logic [2:0] neg_i = '0, abs_i = '0;
  logic [1:0] omod_i = '0;
  logic [W-1:0] src0_i = '0, src1_i = '0, src2_i = '0, res_i = '0;
  logic op_valid_o, res_valid_o;
  logic [W-1:0] src0_o, src1_o, src2_o, res_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp32_modifier_stage #(.LANES(LANES)) u_dut (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pre(input string req, input logic [2:0] n, input logic [2:0] a,
                     input logic [W-1:0] i0, input logic [W-1:0] i1, input logic [W-1:0] i2,
                     input logic [W-1:0] e0, input logic [W-1:0] e1, input logic [W-1:0] e2);
    @(negedge clk);
    op_valid_i = 1'b1; neg_i = n; abs_i = a; src0_i = i0; src1_i = i1; src2_i = i2;
    @(posedge clk); #1;
    op_valid_i = 1'b0;
    check({req, " src0"}, src0_o, e0);
    check({req, " src1"}, src1_o, e1);
    check({req, " src2"}, src2_o, e2);
    check({req, " valid R10"}, {{(W-1){1'b0}}, op_valid_o}, {{(W-1){1'b0}}, 1'b1});
  endtask

  task automatic post(input string req, input logic [1:0] m, input logic c,
                      input logic [W-1:0] r, input logic [W-1:0] e);
    @(negedge clk);
    res_valid_i = 1'b1; omod_i = m; clamp_i = c; res_i = r;
    @(posedge clk); #1;
    res_valid_i = 1'b0;
    check(req, res_o, e);
  endtask

  task automatic t_reset();
    check("R10 reset src0", src0_o, '0);
    check("R10 reset res", res_o, '0);
    check("R10 reset valids", {{(W-2){1'b0}}, op_valid_o, res_valid_o}, '0);
  endtask

  task automatic t_signs();
    // R3 neither on src0, R1 negate on src1, R2 abs on src2
    pre("R1 R2 R3 mixed", 3'b010, 3'b100,
        {32'hBF800000, 32'h7FC00001, 32'h00000000, 32'h40490FDB},
        {32'h40490FDB, 32'hFFC00000, 32'h80000000, 32'h00000001},
        {32'hC0000000, 32'hFF800000, 32'h3F800000, 32'h80000000},
        {32'hBF800000, 32'h7FC00001, 32'h00000000, 32'h40490FDB},
        {32'hC0490FDB, 32'h7FC00000, 32'h00000000, 32'h80000001},
        {32'h40000000, 32'h7F800000, 32'h3F800000, 32'h00000000});
    // R3 both on src0; R4 per-input controls: src1 abs only, src2 untouched
    pre("R3 R4 negabs", 3'b001, 3'b011,
        {32'h3F800000, 32'h80000000, 32'h7FC00000, 32'hC1200000},
        {32'hC1200000, 32'h41200000, 32'hFFFFFFFF, 32'h00000000},
        {32'hC1200000, 32'h41200000, 32'h12345678, 32'h80000000},
        {32'hBF800000, 32'h80000000, 32'hFFC00000, 32'hC1200000},
        {32'h41200000, 32'h41200000, 32'h7FFFFFFF, 32'h00000000},
        {32'hC1200000, 32'h41200000, 32'h12345678, 32'h80000000});
  endtask

  task automatic t_hold();
    @(negedge clk);
    src0_i = '1; neg_i = 3'b111; res_i = '1;
    @(posedge clk); #1;
    check("R10 hold src0", src0_o, {32'hBF800000, 32'h80000000, 32'hFFC00000, 32'hC1200000});
    check("R10 valid low", {{(W-1){1'b0}}, op_valid_o}, '0);
  endtask

  task automatic t_scale();
    post("R5 unity", 2'b00, 1'b0,
         {32'h00000001, 32'h3FC00000, 32'hFF7FFFFF, 32'h80000000},
         {32'h00000001, 32'h3FC00000, 32'hFF7FFFFF, 32'h80000000});
    post("R6 R11 x2", 2'b01, 1'b0,
         {32'h3F800000, 32'h7F000000, 32'hC0400000, 32'h00000005},
         {32'h40000000, 32'h7F800000, 32'hC0C00000, 32'h00000000});
    post("R6 x4", 2'b10, 1'b0,
         {32'h3FC00000, 32'hFF7FFFFF, 32'h7E800000, 32'h80800000},
         {32'h40C00000, 32'hFF800000, 32'h7F800000, 32'h81800000});
    post("R7 half", 2'b11, 1'b0,
         {32'h40000000, 32'h00800000, 32'h80800000, 32'h80000003},
         {32'h3F800000, 32'h00000000, 32'h80000000, 32'h80000000});
    post("R8 special", 2'b10, 1'b0,
         {32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'hFFC00001},
         {32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'hFFC00001});
  endtask

  task automatic t_clamp();
    post("R9 clamp after x2", 2'b01, 1'b1,
         {32'h3F000000, 32'h3F400000, 32'hBF000000, 32'h3E800000},
         {32'h3F800000, 32'h3F800000, 32'h00000000, 32'h3F000000});
    post("R9 clamp unity", 2'b00, 1'b1,
         {32'h80000000, 32'h7FC00000, 32'h7F800000, 32'h3E800000},
         {32'h00000000, 32'h00000000, 32'h3F800000, 32'h3E800000});
    post("R9 clamp half", 2'b11, 1'b1,
         {32'h40000000, 32'h40400000, 32'hFF800000, 32'h3F800000},
         {32'h3F800000, 32'h3F800000, 32'h00000000, 32'h3F000000});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_signs();
    t_hold();
    t_scale();
    t_clamp();
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule